// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds the operations waiting for one functional unit. An issue stage hands it an operation with, for each of its two sources, either a value or the tag of the station that will produce that value. The block parks the operation in a free station and reports the tag that station owns. When every station is occupied, it refuses further issue. The tag zero always means "value present".

Every cycle the block compares the shared result bus against the pending source tags. A match copies the broadcast value into the operand. A station whose two sources are both resolved, and which has not been sent yet, is eligible for dispatch. Among the eligible stations the one issued earliest is offered to the functional unit. Once the unit accepts it, that station is never offered again. The station is released when its own tag is seen on the result bus.

Top module: `rs_bank`

## Requirements
- R1: After reset no station is occupied: `iss_ready` is 1, `disp_valid` is 0 and `iss_tag` equals `TAG_BASE`.
- R2: Station i owns the fixed tag `TAG_BASE + i`. An accepted issue goes to the lowest-numbered free station, and `iss_tag` shows that station's tag in the cycle before the accepting edge.
- R3: `iss_ready` is 0 while all stations are occupied. An issue presented while `iss_ready` is 0 has no effect on any station.
- R4: A source tag of 0 means its value is valid. A held source with a nonzero tag that equals `bus_tag` while `bus_valid` is 1 takes `bus_value` at that edge, and its tag becomes 0.
- R5: An issued source whose nonzero tag matches the result bus in the issue cycle is stored as the broadcast value with tag 0.
- R6: A station is eligible when it is occupied, has not been accepted by the unit, and both source tags are 0. `disp_valid` is 1 exactly when some station is eligible.
- R7: Among eligible stations, the one whose issue came first is presented on the dispatch port.
- R8: A station accepted (`disp_valid` and `disp_ready` both 1) is never presented again until it has been freed and reissued.
- R9: A broadcast carrying an occupied station's own tag frees that station at that edge. A freed station is available for issue in the next cycle.
- R10: The dispatch port carries the selected station's opcode, both operand values, immediate field and tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_ready | output | 1 | A station is free; the issue is taken at this edge |
| iss_tag | output | RS_TAG_W | Tag of the station the next issue will occupy |
| iss_op | input | RS_OP_W | Opcode of the offered operation |
| iss_a_val | input | RS_DATA_W | First source value |
| iss_a_tag | input | RS_TAG_W | First source producer tag, 0 if value valid |
| iss_b_val | input | RS_DATA_W | Second source value |
| iss_b_tag | input | RS_TAG_W | Second source producer tag, 0 if value valid |
| iss_imm | input | RS_IMM_W | Address or immediate field |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | RS_TAG_W | Tag of the broadcasting producer |
| bus_value | input | RS_DATA_W | Broadcast result value |
| disp_valid | output | 1 | An eligible station is offered to the unit |
| disp_ready | input | 1 | Functional unit accepts the offered station |
| disp_tag | output | RS_TAG_W | Tag of the offered station |
| disp_op | output | RS_OP_W | Opcode of the offered station |
| disp_a | output | RS_DATA_W | First operand value |
| disp_b | output | RS_DATA_W | Second operand value |
| disp_imm | output | RS_IMM_W | Address or immediate field |

## Verification
The bench aims at a few cases. A source that matches the bus in its own issue cycle must come out captured; a design that misses it leaves the operation waiting forever on a result already gone. An older station that wakes after a younger one is already offered must take over the dispatch port; a design that picks by index instead sends the younger one first. An accepted station must not return to the port, and a full bank must ignore an offered issue; otherwise operations run twice, or occupied stations are overwritten. A long run issues operations, mixes broadcasts of bank and outside tags and frees them, and toggles unit acceptance at random. This reaches free-and-issue in the same cycle and waits on long-pending tags.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DATA_W = 32;
    localparam int RS_OP_W   = 6;
    localparam int RS_IMM_W  = 16;
    localparam int RS_TAG_W  = 4;

    typedef logic [RS_TAG_W-1:0]  rs_tag_t;
    typedef logic [RS_DATA_W-1:0] rs_data_t;

    // one source: a value, or the producer tag it waits on (0 = value valid)
    typedef struct packed {
        rs_tag_t  tag;
        rs_data_t val;
    } rs_opnd_t;

    typedef struct packed {
        logic [RS_OP_W-1:0]  op;
        rs_opnd_t            a;
        rs_opnd_t            b;
        logic [RS_IMM_W-1:0] imm;
    } rs_uop_t;

    typedef struct packed {
        logic    busy;
        logic    exec;
        rs_uop_t uop;
    } rs_slot_t;

    // resolve a source against the result bus; used both at issue and while held
    function automatic rs_opnd_t rs_snoop(rs_opnd_t o, logic hv, rs_tag_t ht, rs_data_t hval);
        rs_opnd_t r;
        r = o;
        if (hv && (o.tag != '0) && (o.tag == ht)) begin
            r.val = hval;
            r.tag = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter rs_tag_t MY_TAG = 1,
    parameter int      AGE_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  rs_uop_t          alloc_uop,
    input  logic [AGE_W-1:0] alloc_age,
    input  logic             bus_valid,
    input  rs_tag_t          bus_tag,
    input  rs_data_t         bus_value,
    input  logic             free_any,
    input  logic [AGE_W-1:0] free_age,
    input  logic             start,
    output rs_slot_t         slot,
    output logic [AGE_W-1:0] age,
    output logic             hit,
    output logic             ready
);

    assign hit   = slot.busy && bus_valid && (bus_tag == MY_TAG);
    assign ready = slot.busy && !slot.exec
                   && (slot.uop.a.tag == '0) && (slot.uop.b.tag == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            age  <= '0;
        end else if (alloc) begin
            slot.busy      <= 1'b1;
            slot.exec      <= 1'b0;
            slot.uop.op    <= alloc_uop.op;
            slot.uop.imm   <= alloc_uop.imm;
            slot.uop.a     <= rs_snoop(alloc_uop.a, bus_valid, bus_tag, bus_value);
            slot.uop.b     <= rs_snoop(alloc_uop.b, bus_valid, bus_tag, bus_value);
            age            <= alloc_age;
        end else if (hit) begin
            slot.busy <= 1'b0;
            slot.exec <= 1'b0;
        end else if (slot.busy) begin
            if (start) slot.exec <= 1'b1;
            slot.uop.a <= rs_snoop(slot.uop.a, bus_valid, bus_tag, bus_value);
            slot.uop.b <= rs_snoop(slot.uop.b, bus_valid, bus_tag, bus_value);
            // a younger station closes the gap left by a freed older one
            if (free_any && (age > free_age)) age <= age - 1'b1;
        end
    end

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        grant = '0;
        if (any_free) grant[idx] = 1'b1;
    end

endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int N     = 4,
    parameter int AGE_W = 2,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]            ready,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic                    valid,
    output logic [N-1:0]            grant,
    output logic [IDX_W-1:0]        idx
);

    // ages of occupied stations are distinct ranks, 0 = oldest
    for (genvar i = 0; i < N; i++) begin : g_win
        always_comb begin
            grant[i] = ready[i];
            for (int j = 0; j < N; j++) begin
                if ((j != i) && ready[j] && (age[j] < age[i])) grant[i] = 1'b0;
            end
        end
    end

    assign valid = |ready;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int TAG_BASE = 1   // TAG_BASE + NUM_ENT - 1 must fit in RS_TAG_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    output logic                 iss_ready,
    output logic [RS_TAG_W-1:0]  iss_tag,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_DATA_W-1:0] iss_a_val,
    input  logic [RS_TAG_W-1:0]  iss_a_tag,
    input  logic [RS_DATA_W-1:0] iss_b_val,
    input  logic [RS_TAG_W-1:0]  iss_b_tag,
    input  logic [RS_IMM_W-1:0]  iss_imm,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_value,
    output logic                 disp_valid,
    input  logic                 disp_ready,
    output logic [RS_TAG_W-1:0]  disp_tag,
    output logic [RS_OP_W-1:0]   disp_op,
    output logic [RS_DATA_W-1:0] disp_a,
    output logic [RS_DATA_W-1:0] disp_b,
    output logic [RS_IMM_W-1:0]  disp_imm
);

    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int AGE_W = IDX_W;

    rs_slot_t                      slot [NUM_ENT];
    logic [NUM_ENT-1:0][AGE_W-1:0] age;
    logic [NUM_ENT-1:0]            busy_v, ready_v, hit_v, alloc_grant, pick_grant;
    logic [IDX_W-1:0]              alloc_idx, pick_idx;
    logic                          any_free, iss_fire, free_any;
    logic [AGE_W-1:0]              free_age, alloc_age;
    rs_uop_t                       in_uop;

    assign in_uop = '{op: iss_op,
                      a: '{tag: iss_a_tag, val: iss_a_val},
                      b: '{tag: iss_b_tag, val: iss_b_val},
                      imm: iss_imm};

    rs_alloc #(.N(NUM_ENT), .IDX_W(IDX_W)) u_alloc (
        .busy(busy_v), .any_free(any_free), .idx(alloc_idx), .grant(alloc_grant)
    );

    assign iss_ready = any_free;
    assign iss_fire  = iss_valid && any_free;
    assign iss_tag   = RS_TAG_W'(TAG_BASE) + RS_TAG_W'(alloc_idx);

    // rank of a new station = number of stations still held after this edge
    assign free_any  = |hit_v;
    assign alloc_age = AGE_W'($countones(busy_v & ~hit_v));

    always_comb begin
        free_age = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_v[i]) free_age = age[i];
        end
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        rs_entry #(.MY_TAG(rs_tag_t'(TAG_BASE + i)), .AGE_W(AGE_W)) u_ent (
            .clk       (clk),
            .rst       (rst),
            .alloc     (iss_fire && alloc_grant[i]),
            .alloc_uop (in_uop),
            .alloc_age (alloc_age),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .free_any  (free_any),
            .free_age  (free_age),
            .start     (disp_valid && disp_ready && pick_grant[i]),
            .slot      (slot[i]),
            .age       (age[i]),
            .hit       (hit_v[i]),
            .ready     (ready_v[i])
        );
        assign busy_v[i] = slot[i].busy;
    end

    rs_oldest_pick #(.N(NUM_ENT), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
        .ready(ready_v), .age(age), .valid(disp_valid), .grant(pick_grant), .idx(pick_idx)
    );

    assign disp_tag = RS_TAG_W'(TAG_BASE) + RS_TAG_W'(pick_idx);
    assign disp_op  = slot[pick_idx].uop.op;
    assign disp_a   = slot[pick_idx].uop.a.val;
    assign disp_b   = slot[pick_idx].uop.b.val;
    assign disp_imm = slot[pick_idx].uop.imm;

endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk
    import rs_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int TAG_BASE = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          iss_ready,
    input logic [RS_TAG_W-1:0] iss_tag,
    input logic          bus_valid,
    input logic [RS_TAG_W-1:0] bus_tag,
    input logic          disp_valid,
    input logic          disp_ready,
    input logic [RS_TAG_W-1:0] disp_tag
);

    logic own_hit;
    assign own_hit = bus_valid && (int'(bus_tag) >= TAG_BASE)
                     && (int'(bus_tag) < TAG_BASE + NUM_ENT);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (iss_ready && !disp_valid)); // R1

    AST_DISP_TAG_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((int'(disp_tag) >= TAG_BASE) && (int'(disp_tag) < TAG_BASE + NUM_ENT))); // R2

    AST_ISS_TAG_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        iss_ready |-> ((int'(iss_tag) >= TAG_BASE) && (int'(iss_tag) < TAG_BASE + NUM_ENT))); // R2

    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !own_hit) |=> !iss_ready); // R3

    AST_WAITING_STAYS: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready && !(bus_valid && bus_tag == disp_tag)) |=> disp_valid); // R6

    AST_NO_REDISPATCH: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag))); // R8

    AST_FREE_OPENS: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && own_hit) |=> iss_ready); // R9

endmodule

bind rs_bank rs_bank_chk #(.NUM_ENT(NUM_ENT), .TAG_BASE(TAG_BASE)) u_rs_bank_chk (
    .clk(clk), .rst(rst), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag)
);

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
    import rs_pkg::*;

    localparam int N  = 4;
    localparam int TB = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iss_valid = 0, bus_valid = 0, disp_ready = 0;
    logic iss_ready, disp_valid;
    rs_tag_t iss_tag, iss_a_tag = '0, iss_b_tag = '0, bus_tag = '0, disp_tag;
    rs_data_t iss_a_val = '0, iss_b_val = '0, bus_value = '0, disp_a, disp_b;
    logic [RS_OP_W-1:0]  iss_op = '0, disp_op;
    logic [RS_IMM_W-1:0] iss_imm = '0, disp_imm;

    always #10 clk = ~clk;

    rs_bank #(.NUM_ENT(N), .TAG_BASE(TB)) dut (.*);

    int n_chk = 0, n_fail = 0;

    task automatic chk_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural model: per-station fields plus an issue sequence number
    bit        m_busy [N];
    bit        m_exec [N];
    int        m_seq  [N];
    int        m_op   [N];
    int        m_imm  [N];
    longint    m_av   [N];
    longint    m_bv   [N];
    int        m_at   [N];
    int        m_bt   [N];
    int        m_ctr;

    function automatic int m_free();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic int m_win();
        int w = -1;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !m_exec[i] && m_at[i] == 0 && m_bt[i] == 0)
                if (w < 0 || m_seq[i] < m_seq[w]) w = i;
        return w;
    endfunction

    always @(posedge clk) begin
        int w, f;
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_exec[i] = 0; end
            m_ctr = 0;
        end else begin
            w = m_win();
            f = m_free();
            for (int i = 0; i < N; i++) begin
                if (!m_busy[i]) continue;
                if (bus_valid && int'(bus_tag) == TB + i) begin
                    m_busy[i] = 0; m_exec[i] = 0;
                end else begin
                    if (i == w && disp_ready) m_exec[i] = 1;
                    if (bus_valid && m_at[i] != 0 && m_at[i] == int'(bus_tag)) begin m_av[i] = bus_value; m_at[i] = 0; end
                    if (bus_valid && m_bt[i] != 0 && m_bt[i] == int'(bus_tag)) begin m_bv[i] = bus_value; m_bt[i] = 0; end
                end
            end
            if (iss_valid && f >= 0) begin
                m_busy[f] = 1; m_exec[f] = 0; m_seq[f] = m_ctr; m_ctr++;
                m_op[f] = int'(iss_op); m_imm[f] = int'(iss_imm);
                m_av[f] = iss_a_val; m_at[f] = int'(iss_a_tag);
                m_bv[f] = iss_b_val; m_bt[f] = int'(iss_b_tag);
                if (bus_valid && m_at[f] != 0 && m_at[f] == int'(bus_tag)) begin m_av[f] = bus_value; m_at[f] = 0; end
                if (bus_valid && m_bt[f] != 0 && m_bt[f] == int'(bus_tag)) begin m_bv[f] = bus_value; m_bt[f] = 0; end
            end
        end
    end

    always @(negedge clk) begin
        int w, f;
        if (!rst) begin
            w = m_win();
            f = m_free();
            chk_eq("R3", "iss_ready", iss_ready, f >= 0);
            if (f >= 0) chk_eq("R2", "iss_tag", iss_tag, TB + f);
            chk_eq("R6", "disp_valid", disp_valid, w >= 0);
            if (w >= 0) begin
                chk_eq("R7", "disp_tag", disp_tag, TB + w);
                chk_eq("R4", "disp_a", disp_a, m_av[w]);
                chk_eq("R5", "disp_b", disp_b, m_bv[w]);
                chk_eq("R10", "disp_op", disp_op, m_op[w]);
                chk_eq("R10", "disp_imm", disp_imm, m_imm[w]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(int op, longint av, int at, longint bv, int bt);
        iss_valid = 1; iss_op = RS_OP_W'(op); iss_imm = RS_IMM_W'(op * 3);
        iss_a_val = RS_DATA_W'(av); iss_a_tag = RS_TAG_W'(at);
        iss_b_val = RS_DATA_W'(bv); iss_b_tag = RS_TAG_W'(bt);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        step(); step();
        rst = 0;
        step();
        chk_eq("R1", "iss_ready", iss_ready, 1);
        chk_eq("R1", "disp_valid", disp_valid, 0);
        chk_eq("R1", "iss_tag", iss_tag, TB);

        // station 1 waits on an outside tag; stations 2 and 3 are ready
        put(1, 'h11, 7, 'h12, 0); step();
        put(2, 'h21, 0, 'h22, 0); step();
        put(3, 'h31, 0, 'h32, 0); step();
        iss_valid = 0;
        chk_eq("R7", "younger ready first", disp_tag, TB + 1);

        // broadcast wakes station 1; same-cycle issue of station 4 captures it
        bus_valid = 1; bus_tag = 7; bus_value = 'hAAAA;
        put(4, 'h41, 0, 'h42, 7); step();
        bus_valid = 0; iss_valid = 0;
        chk_eq("R7", "woken older wins", disp_tag, TB);
        chk_eq("R4", "captured a", disp_a, 'hAAAA);
        chk_eq("R3", "full stall", iss_ready, 0);

        put(9, 'h99, 0, 'h99, 0); step(); iss_valid = 0;
        chk_eq("R3", "ignored issue", disp_tag, TB);
        chk_eq("R3", "ignored issue a", disp_a, 'hAAAA);

        disp_ready = 1; step(); disp_ready = 0;
        chk_eq("R8", "accepted not reoffered", disp_tag, TB + 1);

        bus_valid = 1; bus_tag = RS_TAG_W'(TB); bus_value = 'h5; step(); bus_valid = 0;
        chk_eq("R9", "freed ready", iss_ready, 1);
        chk_eq("R9", "freed tag", iss_tag, TB);

        disp_ready = 1; step(); step();
        chk_eq("R5", "issue-cycle capture", disp_b, 'hAAAA);
        chk_eq("R10", "op of station 4", disp_op, 4);
        disp_ready = 0;

        rst = 1; step(); step(); rst = 0; step();
        chk_eq("R1", "second reset", disp_valid, 0);

        repeat (4000) begin
            iss_valid  = ($urandom % 2) == 1;
            iss_op     = RS_OP_W'($urandom);
            iss_imm    = RS_IMM_W'($urandom);
            iss_a_val  = $urandom;
            iss_b_val  = $urandom;
            iss_a_tag  = ($urandom % 3 == 0) ? RS_TAG_W'(1 + $urandom % 6) : '0;
            iss_b_tag  = ($urandom % 3 == 0) ? RS_TAG_W'(1 + $urandom % 6) : '0;
            bus_valid  = ($urandom % 3) == 0;
            bus_tag    = RS_TAG_W'($urandom % 7);
            bus_value  = $urandom;
            disp_ready = ($urandom % 2) == 1;
            step();
        end

        summary();
        $finish;
    end

endmodule